// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Front End

This block is the digital register front end of a four-channel, 12-bit converter. Each channel keeps two ranks of storage. The input rank is loaded from a parallel write bus. The output rank is the value a downstream converter core turns into a voltage. A host selects a channel with a 2-bit address and drives a read/write line, an active-low select, an active-low load strobe and an active-low reset.

Every control is sampled on the rising edge of the system clock. On each edge the sampled combination picks exactly one action:

- a write that passes straight through to the output rank,
- a write that stops at the input rank,
- a readback of an input register,
- a simultaneous copy of all four input registers into the output rank,
- a hold,
- a reset that overrides everything else.

The reset code is a build-time parameter. Midscale suits bipolar setups, and zero scale is the other choice.

Top module: `dacq_top`

## Requirements
- R1: `chanSel` values 0, 1, 2 and 3 select channels A, B, C and D. Channel n's output register appears on `dacLevels[12n+11:12n]`.
- R2: In a cycle with `resetN`=1, `csN`=0, `rdWr`=0 and `loadN`=0, both the input and the output register of the addressed channel take `wrData`. The new value shows on `dacLevels` one cycle later.
- R3: In a cycle with `resetN`=1, `csN`=0, `rdWr`=0 and `loadN`=1, only the addressed input register takes `wrData`. All output registers and the other input registers keep their values.
- R4: In a cycle with `resetN`=1, `csN`=0 and `rdWr`=1, the addressed input register is presented on `rdData` with `rdValid`=1 one cycle later. No register changes, whatever `loadN` is.
- R5: In a cycle with `resetN`=1, `csN`=1 and `loadN`=0, all four output registers take the values of their input registers at the same edge.
- R6: In a cycle with `resetN`=1, `csN`=1 and `loadN`=1, every register holds.
- R7: In a cycle with `resetN`=0, all input and output registers take `RESET_CODE` regardless of `csN`, `rdWr`, `loadN`, `chanSel` and `wrData`. In the following cycle `rdValid` is 0.
- R8: `rdValid` is 1 only in the cycle after a readback (R4). In every other cycle `rdValid` is 0 and `rdData` is zero.
- R9: `RESET_CODE` defaults to 12'h800 (midscale). Zero scale is obtained by setting it to 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| resetN | input | 1 | Active-low register reset; overrides all other controls |
| csN | input | 1 | Active-low chip select |
| rdWr | input | 1 | 1 = readback, 0 = write (when selected) |
| loadN | input | 1 | Active-low load strobe |
| chanSel | input | 2 | Channel address, 0..3 = A..D |
| wrData | input | 12 | Write data word |
| rdData | output | 12 | Readback word, zero when not valid |
| rdValid | output | 1 | Readback output enable |
| dacLevels | output | 48 | Four packed output-register values, channel A in the low bits |

## Verification
Every result of this block is due exactly one clock after the edge that samples the controls. That covers register writes seen on `dacLevels`, the broadside load, the reset code, and the readback word with its enable. The bench changes inputs on the falling edge and advances its reference model on the next rising edge. It compares all four channel levels, `rdData` and `rdValid` at the falling edge that follows, so each comparison sees the result of exactly one sampled combination. Directed sequences reach each action and the reset override. A long random run then mixes them, including back-to-back reads, writes and loads.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

  // One-cycle action strobes from the decoder to the register bank
  typedef struct packed {
    logic clear;    // force every register to the reset code
    logic loadAll;  // copy all input registers to the output rank
    logic wrIn;     // write the addressed input register
    logic wrOut;    // write the addressed output register too
    logic rdEn;     // present the addressed input register
  } dacqStrobes_t;

endpackage

// File: rtl/dacq_ctrl.sv
module dacq_ctrl
  import dacq_pkg::*;
(
  input  logic         resetN,
  input  logic         csN,
  input  logic         rdWr,
  input  logic         loadN,
  output dacqStrobes_t strobes
);

  // Priority: reset, then selected access, then unselected load/hold
  always_comb begin
    strobes = '0;
    if (!resetN) begin
      strobes.clear = 1'b1;
    end else if (!csN) begin
      if (rdWr) begin
        strobes.rdEn = 1'b1;
      end else begin
        strobes.wrIn  = 1'b1;
        strobes.wrOut = !loadN;
      end
    end else begin
      strobes.loadAll = !loadN;
    end
  end

endmodule

// File: rtl/dacq_bank.sv
module dacq_bank
  import dacq_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter int                ADDR_W     = 2,
  parameter logic [DATA_W-1:0] RESET_CODE = 12'h800
) (
  input  logic                         clk,
  input  dacqStrobes_t                 strobes,
  input  logic [ADDR_W-1:0]            chanSel,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid,
  output logic [(1<<ADDR_W)*DATA_W-1:0] dacLevels
);

  localparam int NCH    = 1 << ADDR_W;
  localparam int FLAT_W = NCH * DATA_W;

  logic [DATA_W-1:0] inReg  [NCH];
  logic [DATA_W-1:0] outReg [NCH];
  logic [FLAT_W-1:0] inFlat;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic hit;
    assign hit = (chanSel == ADDR_W'(ch));

    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        inReg[ch] <= RESET_CODE;
      end else if (strobes.wrIn && hit) begin
        inReg[ch] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        outReg[ch] <= RESET_CODE;
      end else if (strobes.wrOut && hit) begin
        outReg[ch] <= wrData;
      end else if (strobes.loadAll) begin
        outReg[ch] <= inReg[ch];
      end
    end

    assign dacLevels[ch*DATA_W +: DATA_W] = outReg[ch];
    assign inFlat[ch*DATA_W +: DATA_W]    = inReg[ch];
  end

  always_ff @(posedge clk) begin
    if (strobes.rdEn) begin
      rdData  <= inReg[chanSel];
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

  AST_RESET_CODE: assert property (@(posedge clk)
    strobes.clear |=> (dacLevels == {NCH{RESET_CODE}}) && (inFlat == {NCH{RESET_CODE}}) && !rdValid); // R7

  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.loadAll |=> dacLevels == $past(inFlat)); // R5

  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.rdEn |=> rdValid && $stable(dacLevels) && $stable(inFlat)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.wrIn && !strobes.rdEn && !strobes.loadAll |=> $stable(dacLevels) && $stable(inFlat)); // R6

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (strobes.clear)
    !rdValid |-> rdData == '0); // R8

endmodule

// File: rtl/dacq_top.sv
module dacq_top
  import dacq_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter int                ADDR_W     = 2,
  parameter logic [DATA_W-1:0] RESET_CODE = 12'h800
) (
  input  logic                          clk,
  input  logic                          resetN,
  input  logic                          csN,
  input  logic                          rdWr,
  input  logic                          loadN,
  input  logic [ADDR_W-1:0]             chanSel,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic [(1<<ADDR_W)*DATA_W-1:0] dacLevels
);

  dacqStrobes_t strobes;

  dacq_ctrl u_ctrl (
    .resetN (resetN),
    .csN    (csN),
    .rdWr   (rdWr),
    .loadN  (loadN),
    .strobes(strobes)
  );

  dacq_bank #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .RESET_CODE(RESET_CODE)
  ) u_bank (
    .clk      (clk),
    .strobes  (strobes),
    .chanSel  (chanSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .dacLevels(dacLevels)
  );

endmodule

// File: tb/sim_dacq_top.sv
module sim_dacq_top;

  localparam int CLK_PERIOD = 10;
  localparam int RST_CODE   = 'h800;

  logic        clk = 1'b0;
  logic        resetN = 1'b0, csN = 1'b1, rdWr = 1'b0, loadN = 1'b1;
  logic [1:0]  chanSel = '0;
  logic [11:0] wrData = '0;
  logic [11:0] rdData;
  logic        rdValid;
  logic [47:0] dacLevels;

  int vectors = 0;
  int misses  = 0;
  int inRef[4];
  int outRef[4];
  int rdRef    = 0;
  int validRef = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacq_top u0 (
    .clk(clk), .resetN(resetN), .csN(csN), .rdWr(rdWr), .loadN(loadN),
    .chanSel(chanSel), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .dacLevels(dacLevels)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // Watchdog: an expired run counts as a miscompare
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      misses++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 50000", cycles);
      finish_run();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one combination at the falling edge, update the model at the
  // sampling edge, compare at the next falling edge.
  task automatic step(string tag, bit rst, bit cs, bit rw, bit ld, int ch, int d);
    @(negedge clk);
    resetN = rst; csN = cs; rdWr = rw; loadN = ld;
    chanSel = 2'(ch); wrData = 12'(d);
    @(posedge clk);
    validRef = 0; rdRef = 0;
    if (!rst) begin
      for (int i = 0; i < 4; i++) begin inRef[i] = RST_CODE; outRef[i] = RST_CODE; end
    end else if (!cs && !rw) begin
      inRef[ch] = d & 'hfff;
      if (!ld) outRef[ch] = d & 'hfff;
    end else if (!cs && rw) begin
      rdRef = inRef[ch]; validRef = 1;
    end else if (!ld) begin
      for (int i = 0; i < 4; i++) outRef[i] = inRef[i];
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      check(tag, $sformatf("R1 dacLevels ch%0d", i), int'(dacLevels[i*12 +: 12]), outRef[i]);
    check(tag, "R8 rdValid", int'(rdValid), validRef);
    check(tag, "R8 rdData", int'(rdData), rdRef);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin inRef[i] = 0; outRef[i] = 0; end
    // R7 R9: reset drives the midscale code everywhere
    step("R7", 0, 0, 0, 0, 1, 'h123);
    step("R9", 1, 1, 0, 1, 0, 0);
    // R3 R1: input-only writes to each channel, outputs hold
    step("R3", 1, 0, 0, 1, 0, 'h111);
    step("R3", 1, 0, 0, 1, 1, 'h222);
    step("R3", 1, 0, 0, 1, 2, 'h333);
    step("R3", 1, 0, 0, 1, 3, 'h444);
    // R4: readback each input register, load strobe low must not matter
    for (int c = 0; c < 4; c++) step("R4", 1, 0, 1, c % 2, c, 'hfff);
    // R5: broadside load
    step("R5", 1, 1, 0, 0, 0, 0);
    // R6: hold with noise on data and address
    step("R6", 1, 1, 1, 1, 2, 'habc);
    // R2: transparent write
    step("R2", 1, 0, 0, 0, 2, 'h9a5);
    step("R3", 1, 0, 0, 1, 1, 'h0f0);
    step("R6", 1, 1, 0, 1, 1, 'h555);
    step("R4", 1, 0, 1, 1, 1, 0);
    // R7: reset mid-operation while a write is requested
    step("R7", 0, 0, 0, 0, 3, 'h777);
    step("R8", 1, 0, 1, 0, 3, 0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 19);
      step("R8", r != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(0, 4095));
    end
    finish_run();
  end

endmodule